// File: doc/BRIEF.md
# Motion Delta Accumulator with Read-Clear

This block collects per-frame signed displacement counts for two axes and holds them in a pair of 8-bit two's-complement registers that a host reads through a register port. Each frame update from the motion source carries a valid strobe and one signed count per axis. The block adds these counts to the running totals and clamps them at the 8-bit limits. It also keeps a sticky motion flag that tells the host whether anything has moved since the flag was last read.

The register port gives the block single-cycle read strobes, one per delta register and one for the motion status register, plus a write strobe for the motion status register. Reading a delta register returns the count collected since it was last read and then zeroes that register. Writing the status register with any value discards all pending motion. A resolution select chooses between the native count rate and a halved rate. At the halved rate the odd count left over on each axis is carried into the next frame, so slow motion is not lost.

Top module: `motion_accum`

## Requirements
- R1: After reset, `delta_x`, `delta_y` and `motion_reg` all read 0.
- R2: With `res_hi`=1 (native rate), each cycle with `frame_valid`=1 adds the signed `frame_dx`/`frame_dy` count to the matching accumulator, and the result is visible one cycle later.
- R3: An accumulator saturates at +127 (0x7F) and at −128 (0x80) and never wraps.
- R4: With `res_hi`=0 (half rate), each axis adds its frame count to its carried remainder. The sum is halved with truncation toward zero and added to the accumulator. The leftover (−1, 0 or +1) is stored as that axis's remainder for its next frame.
- R5: A `rd_x` strobe zeroes `delta_x` one cycle later, and `rd_y` does the same for `delta_y`. Neither strobe touches the other axis.
- R6: When a read strobe and `frame_valid` fall in the same cycle, the register's next value is the new frame's scaled count alone, so no motion is lost.
- R7: `motion_reg` carries the flag in bit 7, and bits 6..0 always read 0. The flag is set by any frame update after which either accumulator is nonzero.
- R8: The flag stays set until a `rd_mot` or `wr_motion` strobe. Delta reads leave it unchanged. A frame update that leaves an accumulator nonzero in the same cycle as a clear keeps the flag set.
- R9: A `wr_motion` strobe clears the flag, both accumulators and both half-rate remainders. A frame arriving in the same cycle is then applied on top of the cleared state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | Frame counts valid this cycle |
| frame_dx | input | 8 | Signed X count of the frame |
| frame_dy | input | 8 | Signed Y count of the frame |
| res_hi | input | 1 | 1 = native rate, 0 = half rate |
| rd_x | input | 1 | Read strobe of the X delta register |
| rd_y | input | 1 | Read strobe of the Y delta register |
| rd_mot | input | 1 | Read strobe of the motion status register |
| wr_motion | input | 1 | Write strobe of the motion status register |
| delta_x | output | 8 | Accumulated X count, two's complement |
| delta_y | output | 8 | Accumulated Y count, two's complement |
| motion_reg | output | 8 | Motion status, flag in bit 7 |

## Verification
The assertions check on every cycle that status bits 6..0 stay zero and that a register holds its value when no frame, read or write touches it. They also check that read and write clears take effect one cycle later, that the flag stays set until cleared, and that an accumulator at +127 stays there under non-negative input. Only the bench's scenarios can show the arithmetic itself. These are the exact sums at native rate across every frame value, the half-rate truncation and remainder carry across consecutive frames, and the handling of reads and writes that coincide with frames. A long mixed sequence of both rates and random strobes is compared against an arithmetic model.

// File: rtl/motion_accum_pkg.sv
package motion_accum_pkg;
    localparam int NUM_AXES = 2;
    localparam int AX_X     = 0;
    localparam int AX_Y     = 1;

    typedef enum logic {
        RES_HALF   = 1'b0,
        RES_NATIVE = 1'b1
    } res_e;
endpackage

// File: rtl/motion_scaler.sv
// Resolution scaler for one axis: passes the native count through, or halves
// (count + carried remainder) toward zero and returns the new remainder.
module motion_scaler #(
    parameter int DW = 8
) (
    input  logic signed [DW-1:0] raw_i,
    input  logic signed [1:0]    rem_i,
    input  logic                 half_i,
    output logic signed [DW:0]   scaled_o,
    output logic signed [1:0]    rem_o
);
    logic signed [DW:0] total;
    logic signed [DW:0] adj;
    logic signed [DW:0] halved;
    logic signed [DW:0] twice;
    logic signed [DW:0] diff;

    always_comb begin
        total  = {raw_i[DW-1], raw_i} + {{(DW-1){rem_i[1]}}, rem_i};
        // bias negative sums by one so the arithmetic shift truncates toward zero
        adj    = total + {{DW{1'b0}}, total[DW]};
        halved = adj >>> 1;
        twice  = halved <<< 1;
        diff   = total - twice;
        if (half_i) begin
            scaled_o = halved;
            rem_o    = diff[1:0];
        end else begin
            scaled_o = {raw_i[DW-1], raw_i};
            rem_o    = '0;
        end
    end
endmodule

// File: rtl/sat_accum.sv
// Saturating signed add of an increment onto an accumulator value.
module sat_accum #(
    parameter int IW = 9,
    parameter int AW = 8
) (
    input  logic signed [AW-1:0] base_i,
    input  logic signed [IW-1:0] inc_i,
    output logic signed [AW-1:0] sum_o
);
    localparam int SW = ((IW > AW) ? IW : AW) + 1;
    localparam logic signed [SW-1:0] MAXV = SW'((1 << (AW - 1)) - 1);
    localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);

    logic signed [SW-1:0] wide;

    always_comb begin
        wide = SW'(base_i) + SW'(inc_i);
        if (wide > MAXV)      sum_o = MAXV[AW-1:0];
        else if (wide < MINV) sum_o = MINV[AW-1:0];
        else                  sum_o = wide[AW-1:0];
    end
endmodule

// File: rtl/motion_accum.sv
module motion_accum
    import motion_accum_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_valid,
    input  logic [DW-1:0] frame_dx,
    input  logic [DW-1:0] frame_dy,
    input  logic          res_hi,
    input  logic          rd_x,
    input  logic          rd_y,
    input  logic          rd_mot,
    input  logic          wr_motion,
    output logic [AW-1:0] delta_x,
    output logic [AW-1:0] delta_y,
    output logic [7:0]    motion_reg
);
    localparam int IW = DW + 1;
    localparam int RW = 2;

    typedef struct packed {
        logic [NUM_AXES-1:0][AW-1:0] acc;
        logic [NUM_AXES-1:0][RW-1:0] rem;
        logic                        mot;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_AXES-1:0][DW-1:0] raw;
    logic [NUM_AXES-1:0]         rd_ax;
    logic [NUM_AXES-1:0][AW-1:0] base;
    logic [NUM_AXES-1:0][RW-1:0] rem_in;
    logic [NUM_AXES-1:0][IW-1:0] scaled;
    logic [NUM_AXES-1:0][RW-1:0] rem_new;
    logic [NUM_AXES-1:0][AW-1:0] sum;
    logic                        half_mode;
    logic                        any_nz;

    assign raw[AX_X]   = frame_dx;
    assign raw[AX_Y]   = frame_dy;
    assign rd_ax[AX_X] = rd_x;
    assign rd_ax[AX_Y] = rd_y;
    assign half_mode   = (res_e'(res_hi) == RES_HALF);

    generate
        for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
            assign base[a]   = (wr_motion || rd_ax[a]) ? '0 : s_q.acc[a];
            assign rem_in[a] = wr_motion ? '0 : s_q.rem[a];

            motion_scaler #(.DW(DW)) u_scale (
                .raw_i    (raw[a]),
                .rem_i    (rem_in[a]),
                .half_i   (half_mode),
                .scaled_o (scaled[a]),
                .rem_o    (rem_new[a])
            );

            sat_accum #(.IW(IW), .AW(AW)) u_sat (
                .base_i (base[a]),
                .inc_i  (scaled[a]),
                .sum_o  (sum[a])
            );
        end
    endgenerate

    always_comb begin
        s_d    = s_q;
        any_nz = 1'b0;
        for (int a = 0; a < NUM_AXES; a++) begin
            if (frame_valid) begin
                s_d.acc[a] = sum[a];
                s_d.rem[a] = rem_new[a];
            end else begin
                s_d.acc[a] = base[a];
                s_d.rem[a] = rem_in[a];
            end
            any_nz = any_nz | (s_d.acc[a] != '0);
        end
        s_d.mot = (s_q.mot & ~(rd_mot | wr_motion)) | (frame_valid & any_nz);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign delta_x    = s_q.acc[AX_X];
    assign delta_y    = s_q.acc[AX_Y];
    assign motion_reg = {s_q.mot, 7'b0};
endmodule

// File: rtl/motion_accum_chk.sv
module motion_accum_chk #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_valid,
    input logic [DW-1:0] frame_dx,
    input logic          res_hi,
    input logic          rd_x,
    input logic          rd_y,
    input logic          rd_mot,
    input logic          wr_motion,
    input logic [AW-1:0] delta_x,
    input logic [AW-1:0] delta_y,
    input logic [7:0]    motion_reg
);
    localparam logic [AW-1:0] POS_MAX = AW'((1 << (AW - 1)) - 1);

    always @(posedge clk) begin
        if (rst_n) begin
            p_low_bits_r7: assert (motion_reg[6:0] == 7'b0)
                else $error("status low bits nonzero");
        end
    end

    p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_motion && !frame_valid) |=> (delta_x == '0 && delta_y == '0 && !motion_reg[7]))
        else $error("write did not clear");

    p_rd_x_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_x && !frame_valid) |=> (delta_x == '0))
        else $error("X read did not clear");

    p_rd_y_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_y && !frame_valid) |=> (delta_y == '0))
        else $error("Y read did not clear");

    p_hold_x_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_valid && !rd_x && !wr_motion) |=> $stable(delta_x))
        else $error("X changed without cause");

    p_mot_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (motion_reg[7] && !rd_mot && !wr_motion) |=> motion_reg[7])
        else $error("flag dropped without clear");

    p_sat_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (delta_x == POS_MAX && frame_valid && res_hi && !frame_dx[DW-1]
         && !rd_x && !wr_motion) |=> (delta_x == POS_MAX))
        else $error("X wrapped past maximum");
endmodule

bind motion_accum motion_accum_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .frame_dx    (frame_dx),
    .res_hi      (res_hi),
    .rd_x        (rd_x),
    .rd_y        (rd_y),
    .rd_mot      (rd_mot),
    .wr_motion   (wr_motion),
    .delta_x     (delta_x),
    .delta_y     (delta_y),
    .motion_reg  (motion_reg)
);

// File: tb/motion_accum_test.sv
`timescale 1ns/1ps
module motion_accum_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_valid = 1'b0;
    logic [7:0] frame_dx = '0;
    logic [7:0] frame_dy = '0;
    logic       res_hi = 1'b1;
    logic       rd_x = 1'b0;
    logic       rd_y = 1'b0;
    logic       rd_mot = 1'b0;
    logic       wr_motion = 1'b0;
    logic [7:0] delta_x;
    logic [7:0] delta_y;
    logic [7:0] motion_reg;

    int checks = 0;
    int errors = 0;

    // bench model state
    int m_acc[2];
    int m_rem[2];
    bit m_mot;

    always #2.5 clk = ~clk;

    motion_accum uut (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
        .frame_dx(frame_dx), .frame_dy(frame_dy), .res_hi(res_hi),
        .rd_x(rd_x), .rd_y(rd_y), .rd_mot(rd_mot), .wr_motion(wr_motion),
        .delta_x(delta_x), .delta_y(delta_y), .motion_reg(motion_reg)
    );

    function automatic int clamp8(input int v);
        if (v > 127)  return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    task automatic compare(input string tag);
        int ax = int'($signed(delta_x));
        int ay = int'($signed(delta_y));
        checks++;
        if (ax != m_acc[0] || ay != m_acc[1] || motion_reg != {m_mot, 7'b0}) begin
            errors++;
            $display("FAIL %s: got dx=%0d dy=%0d st=%02h, expected dx=%0d dy=%0d st=%02h",
                     tag, ax, ay, motion_reg, m_acc[0], m_acc[1], {m_mot, 7'b0});
        end
    endtask

    // drive one cycle of stimulus at the falling edge, update the model, check after the rising edge
    task automatic step(input bit fv, input int dx, input int dy, input bit rx, input bit ry,
                        input bit rm, input bit wm, input string tag);
        int d[2];
        bit rd[2];
        bit nz;
        frame_valid = fv; frame_dx = 8'(dx); frame_dy = 8'(dy);
        rd_x = rx; rd_y = ry; rd_mot = rm; wr_motion = wm;
        d[0] = dx; d[1] = dy; rd[0] = rx; rd[1] = ry;
        @(posedge clk);
        #1;
        nz = 1'b0;
        for (int a = 0; a < 2; a++) begin
            int base = (wm || rd[a]) ? 0 : m_acc[a];
            int remi = wm ? 0 : m_rem[a];
            if (fv) begin
                int inc;
                if (res_hi) begin
                    inc = d[a]; m_rem[a] = 0;
                end else begin
                    int tot = d[a] + remi;
                    inc = tot / 2;
                    m_rem[a] = tot - 2 * inc;
                end
                m_acc[a] = clamp8(base + inc);
            end else begin
                m_acc[a] = base;
                m_rem[a] = remi;
            end
            if (m_acc[a] != 0) nz = 1'b1;
        end
        m_mot = (m_mot && !(rm || wm)) || (fv && nz);
        compare(tag);
        @(negedge clk);
        frame_valid = 0; rd_x = 0; rd_y = 0; rd_mot = 0; wr_motion = 0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed = 32'h1234_5678;
        m_acc[0] = 0; m_acc[1] = 0; m_rem[0] = 0; m_rem[1] = 0; m_mot = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset state");

        // R2: every frame value at native rate from a cleared state
        res_hi = 1'b1;
        for (int v = -128; v < 128; v++) begin
            step(0, 0, 0, 0, 0, 0, 1, "R9 clear");
            step(1, v, -v - 1, 0, 0, 0, 0, "R2 native sweep");
        end

        // R4: every frame value at half rate, twice, so the remainder carries
        res_hi = 1'b0;
        for (int v = -128; v < 128; v++) begin
            step(0, 0, 0, 0, 0, 0, 1, "R9 clear");
            step(1, v, -v - 1, 0, 0, 0, 0, "R4 half first frame");
            step(1, v, -v - 1, 0, 0, 0, 0, "R4 half carried frame");
        end

        // R3: saturation both ways on both axes
        res_hi = 1'b1;
        step(0, 0, 0, 0, 0, 0, 1, "R9 clear");
        for (int i = 0; i < 3; i++) step(1, 100, -100, 0, 0, 0, 0, "R3 saturate");
        for (int i = 0; i < 4; i++) step(1, -128, 127, 0, 0, 0, 0, "R3 saturate reverse");

        // R5, R8: single-axis reads leave the other axis and the flag intact
        step(0, 0, 0, 0, 0, 0, 1, "R9 clear");
        step(1, 5, -7, 0, 0, 0, 0, "R2 load");
        step(0, 0, 0, 1, 0, 0, 0, "R5 read X only");
        step(0, 0, 0, 0, 1, 0, 0, "R5 read Y only, R8 flag kept");

        // R6: read coincides with a frame
        step(1, 20, 30, 0, 0, 0, 0, "R2 load");
        step(1, -3, 4, 1, 1, 0, 0, "R6 read with frame");

        // R7, R8: flag behaviour
        step(0, 0, 0, 0, 0, 1, 0, "R8 status read clears flag");
        step(0, 0, 0, 1, 1, 0, 0, "R5 drain");
        step(1, 0, 0, 0, 0, 0, 0, "R7 zero frame leaves flag clear");
        step(1, 1, 0, 0, 0, 0, 0, "R7 flag set");
        step(1, -1, 0, 0, 0, 0, 0, "R8 flag stays when sum returns to zero");
        step(1, 2, 0, 0, 0, 1, 0, "R8 frame with status read keeps flag");

        // R9: write with a frame, and remainder discard
        step(1, 9, -9, 0, 0, 0, 1, "R9 write with frame");
        res_hi = 1'b0;
        step(0, 0, 0, 0, 0, 0, 1, "R9 clear");
        step(1, 1, -1, 0, 0, 0, 0, "R4 odd frame leaves remainder");
        step(0, 0, 0, 0, 0, 0, 1, "R9 write drops remainder");
        step(1, 1, -1, 0, 0, 0, 0, "R9 remainder was cleared");

        // mixed sequence over both rates
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            seed = seed * 32'd1103515245 + 32'd12345;
            r = seed;
            if ((i % 300) == 0) res_hi = ~res_hi;
            step(r[31], int'($signed(r[23:16])), int'($signed(r[15:8])),
                 r[3:0] == 4'd0, r[7:4] == 4'd0, r[11:8] == 4'd1, r[27:24] == 4'd5,
                 "R2 R3 R4 R5 R6 R7 R8 R9 mixed");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule